// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Enable Controller

This block receives a write-only configuration stream over a two-wire serial bus (I2C, standard mode, receive side only) and uses it to gate one incoming clock onto eighteen outputs. A system clock much faster than the serial clock oversamples both bus lines. A two-flop synchronizer cleans them up. The controller then detects START and STOP conditions, assembles bytes MSB first and pulls the data line low to acknowledge.

A transfer opens with the 7-bit device address and a write direction bit. Two header bytes follow whose contents are discarded. After them come up to three payload bytes, and these land in three 8-bit enable registers strictly in arrival order. There is no pointer and no readback. Each enable bit either passes the broadcast clock to its output or holds that output low. A separate output-enable input switches every output driver off. The outputs are presented as a level vector plus a per-output drive-enable vector, which the pad ring turns into tri-state pins.

Top module: `clkfan_i2c_top`

## Requirements
- R1: After reset all 24 enable bits are 1, so every output carries the input clock.
- R2: An address byte of 1101001 followed by R/W = 0 (byte value 0xD2) is acknowledged by asserting `sda_pull_low` during the ninth SCL pulse. Any other address, or R/W = 1, gets no acknowledge, and no later byte is acknowledged or stored until the next START.
- R3: After the address the block takes a command byte, then a count byte, then payload bytes 0, 1 and 2. It acknowledges each of them, and the values of the command and count bytes have no effect on the outputs.
- R4: A STOP after payload byte 0 or payload byte 1 leaves the registers not yet reached at their previous values.
- R5: Output index 0..7 is gated by payload byte 0 bits 0..7, index 8..15 by byte 1 bits 0..7, index 16 by byte 2 bit 6 and index 17 by byte 2 bit 7. Bits 0..5 of byte 2 affect no output.
- R6: An output whose enable bit is 0 has level 0 whatever `clk_in` does. An output whose enable bit is 1 has the level of `clk_in`.
- R7: With `oe` low every bit of `out_drive` is 0. With `oe` high every bit is 1.
- R8: A START that arrives inside a transfer (repeated START) aborts it. Nothing is acknowledged or stored until a STOP and then a fresh START.
- R9: A byte after payload byte 2 is not acknowledged and changes no register.
- R10: A payload byte reaches its register only after the SCL falling edge that ends its acknowledge pulse. While that pulse is still high, the outputs keep their old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line as seen at the pin |
| sda_i | input | 1 | Serial bus data line as seen at the pin |
| sda_pull_low | output | 1 | Open-drain control: 1 pulls the data line low (acknowledge) |
| clk_in | input | 1 | Broadcast clock to be fanned out |
| oe | input | 1 | Global output-driver enable, active high |
| out_level | output | 18 | Gated clock level for each output |
| out_drive | output | 18 | Driver enable for each output, 0 means high impedance |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, three 8-bit payload registers and the 0x69 device address. It runs the serial clock at forty system clocks per bit, which leaves room to probe the outputs in the middle of an acknowledge pulse and so to see exactly when a byte is committed. With three registers it can reach every length of a partial transfer, the surplus seventh byte and the reserved bits of the last register.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int HDR_BYTES  = 3;   // address, command, count
    localparam int DATA_BYTES = 3;   // payload registers
    localparam int TOTAL_BYTES = HDR_BYTES + DATA_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for START (also after a refused address)
        ST_RECV = 2'd1,   // shifting in a byte
        ST_ACK  = 2'd2,   // driving acknowledge during ninth pulse
        ST_HOLD = 2'd3    // aborted by repeated START, waiting for STOP
    } slv_state_e;

    typedef struct packed {
        slv_state_e state;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [2:0] bytecnt;
        logic       ack;
        logic       commit;
        logic [1:0] cidx;
        logic [7:0] cdata;
    } slv_regs_t;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_d, scl_q;
    logic [STAGES-1:0] sda_d, sda_q;
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                scl_d = scl_i;
                sda_d = sda_i;
            end
        end else begin : g_chain
            always_comb begin
                scl_d = {scl_q[STAGES-2:0], scl_i};
                sda_d = {sda_q[STAGES-2:0], sda_i};
            end
        end
    endgenerate

    always_comb begin
        scl_prev_d = scl_q[STAGES-1];
        sda_prev_d = sda_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s && !scl_prev_q;
    assign scl_fall  = !scl_s && scl_prev_q;
    assign start_det = scl_s && scl_prev_q && sda_prev_q && !sda_s;
    assign stop_det  = scl_s && scl_prev_q && !sda_prev_q && sda_s;

endmodule

// File: rtl/serial_wr_slave.sv
module serial_wr_slave
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       ack,
    output logic       commit,
    output logic [1:0] commit_idx,
    output logic [7:0] commit_data
);

    localparam logic [2:0] FIRST_DATA = 3'(HDR_BYTES);
    localparam logic [2:0] LAST_BYTE  = 3'(TOTAL_BYTES - 1);

    slv_regs_t r_d, r_q;
    logic      accept;

    always_comb begin
        r_d        = r_q;
        r_d.commit = 1'b0;
        accept     = 1'b0;

        if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.ack   = 1'b0;
        end else if (start_det) begin
            if (r_q.state == ST_RECV || r_q.state == ST_ACK) begin
                r_d.state = ST_HOLD;
                r_d.ack   = 1'b0;
            end else if (r_q.state == ST_IDLE) begin
                r_d.state   = ST_RECV;
                r_d.bitcnt  = 4'd0;
                r_d.bytecnt = 3'd0;
                r_d.ack     = 1'b0;
            end
        end else begin
            case (r_q.state)
                ST_RECV: begin
                    if (scl_rise && r_q.bitcnt < 4'd8) begin
                        r_d.shreg  = {r_q.shreg[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        if (r_q.bytecnt == 3'd0) begin
                            accept = (r_q.shreg[7:1] == DEV_ADDR) && !r_q.shreg[0];
                        end else begin
                            accept = (r_q.bytecnt <= LAST_BYTE);
                        end
                        if (accept) begin
                            r_d.state = ST_ACK;
                            r_d.ack   = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.ack     = 1'b0;
                        r_d.state   = ST_RECV;
                        r_d.bitcnt  = 4'd0;
                        r_d.bytecnt = r_q.bytecnt + 3'd1;
                        if (r_q.bytecnt >= FIRST_DATA) begin
                            r_d.commit = 1'b1;
                            r_d.cidx   = 2'(r_q.bytecnt - FIRST_DATA);
                            r_d.cdata  = r_q.shreg;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, bitcnt: 4'd0, shreg: 8'd0, bytecnt: 3'd0,
                     ack: 1'b0, commit: 1'b0, cidx: 2'd0, cdata: 8'd0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack         = r_q.ack;
    assign commit      = r_q.commit;
    assign commit_idx  = r_q.cidx;
    assign commit_data = r_q.cdata;

endmodule

// File: rtl/enable_bank.sv
module enable_bank #(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 8,
    parameter int IDX_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [IDX_W-1:0]          load_idx,
    input  logic [REG_W-1:0]          load_data,
    output logic [NUM_REGS*REG_W-1:0] bits
);

    logic [NUM_REGS-1:0][REG_W-1:0] bank_d, bank_q;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_comb begin
                bank_d[g] = bank_q[g];
                if (load && (load_idx == IDX_W'(g))) begin
                    bank_d[g] = load_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bits = bank_q;

endmodule

// File: rtl/clkfan_i2c_top.sv
module clkfan_i2c_top
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         REG_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_low,
    input  logic                    clk_in,
    input  logic                    oe,
    output logic [2*REG_W+1:0]      out_level,
    output logic [2*REG_W+1:0]      out_drive
);

    localparam int NUM_OUT   = 2 * REG_W + 2;
    localparam int PAIR_OUTS = 2 * REG_W;       // outputs fed by two full registers
    localparam int TAIL_LSB  = REG_W - 2;       // first used bit of last register
    localparam int EN_W      = DATA_BYTES * REG_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              commit;
    logic [1:0]        commit_idx;
    logic [7:0]        commit_data;
    logic [EN_W-1:0]   en_bits;
    logic [NUM_OUT-1:0] en_map;

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    serial_wr_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .ack         (sda_pull_low),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    enable_bank #(.NUM_REGS(DATA_BYTES), .REG_W(REG_W), .IDX_W(2)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (commit),
        .load_idx  (commit_idx),
        .load_data (commit_data[REG_W-1:0]),
        .bits      (en_bits)
    );

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
            if (i < PAIR_OUTS) begin : g_full
                assign en_map[i] = en_bits[i];
            end else begin : g_tail
                assign en_map[i] = en_bits[PAIR_OUTS + TAIL_LSB + (i - PAIR_OUTS)];
            end
        end
    endgenerate

    assign out_level = en_map & {NUM_OUT{clk_in}};
    assign out_drive = {NUM_OUT{oe}};

endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        sda_pull_low,
    input logic        commit,
    input logic [1:0]  commit_idx,
    input logic [23:0] en_bits,
    input logic        clk_in,
    input logic        oe,
    input logic [17:0] out_level,
    input logic [17:0] out_drive
);

    // R1: enables come out of reset all set
    a_r1_reset_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_bits == 24'hFF_FFFF));

    // R2: acknowledge only starts while the clock line is low
    a_r2_ack_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_s);

    // R2: data line left alone while the clock line stays high
    a_r2_ack_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_low));

    // R10: commit happens with SCL low and names a real register
    a_r10_commit_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!scl_s && commit_idx < 2'd3));

    // R10: a commit never coincides with an active acknowledge
    a_r10_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !sda_pull_low);

    // R6: no output is high while the broadcast clock is low
    a_r6_low_clock_low_out: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_in |-> (out_level == 18'd0));

    // R7: drivers off whenever the global enable is low
    a_r7_oe_low_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (out_drive == 18'd0));

endmodule

bind clkfan_i2c_top clkfan_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .sda_pull_low (sda_pull_low),
    .commit       (commit),
    .commit_idx   (commit_idx),
    .en_bits      (en_bits),
    .clk_in       (clk_in),
    .oe           (oe),
    .out_level    (out_level),
    .out_drive    (out_drive)
);

// File: tb/tb_clkfan_i2c_top.sv
module tb_clkfan_i2c_top;

    localparam int Q = 10;   // quarter bit in system clocks
    localparam int H = 20;   // half bit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_pull_low;
    logic        clk_in = 1'b0;
    logic        oe = 1'b1;
    logic [17:0] out_level, out_drive;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;
    logic [7:0]  mdl [3];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    clkfan_i2c_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_pull_low (sda_pull_low),
        .clk_in       (clk_in),
        .oe           (oe),
        .out_level    (out_level),
        .out_drive    (out_drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [17:0] exp_en();
        return {mdl[2][7], mdl[2][6], mdl[1], mdl[0]};
    endfunction

    task automatic check_outs(input string tag);
        clk_in = 1'b1; #1;
        chk({tag, " level clk high"}, 32'(out_level), 32'(exp_en()));
        chk({tag, " drive"}, 32'(out_drive), 32'h3FFFF);
        @(negedge clk); clk_in = 1'b0; #1;
        chk({tag, " level clk low"}, 32'(out_level), 32'd0);
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b; wait_clks(Q);
        scl = 1'b1; wait_clks(H);
        scl = 1'b0; wait_clks(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(Q);
        scl = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl = 1'b0; wait_clks(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(Q);
        scl = 1'b1; wait_clks(H);
        sda_m = 1'b1; wait_clks(H);
    endtask

    task automatic send_bits(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic got_ack);
        send_bits(v);
        sda_m = 1'b1; wait_clks(Q);
        scl = 1'b1; wait_clks(H / 2);
        got_ack = sda_pull_low;
        wait_clks(H / 2);
        scl = 1'b0; wait_clks(Q);
    endtask

    task automatic expect_ack(input string tag, input logic [7:0] v, input logic exp);
        logic a;
        send_byte(v, a);
        chk(tag, 32'(a), 32'(exp));
    endtask

    task automatic write_regs(input string tag, input int n_data, input logic [7:0] cmd,
                              input logic [7:0] cnt, input logic [7:0] d0,
                              input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        expect_ack({tag, " R2 address ack"}, 8'hD2, 1'b1);
        expect_ack({tag, " R3 command ack"}, cmd, 1'b1);
        expect_ack({tag, " R3 count ack"}, cnt, 1'b1);
        for (int i = 0; i < n_data; i++) begin
            expect_ack({tag, " R3 data ack"}, dv[i], 1'b1);
            mdl[i] = dv[i];
        end
        bus_stop();
        wait_clks(8);
    endtask

    task automatic t_reset();
        check_outs("R1 reset");
    endtask

    task automatic t_full();
        write_regs("full", 3, 8'h5A, 8'h03, 8'hA5, 8'h3C, 8'h40);
        check_outs("R5 R6 full write");
        write_regs("hdr", 3, 8'hFF, 8'h00, 8'h5A, 8'hC3, 8'h80);
        check_outs("R3 header values ignored");
    endtask

    task automatic t_partial();
        write_regs("part1", 1, 8'h00, 8'h01, 8'h0F, 8'h00, 8'h00);
        check_outs("R4 stop after byte 0");
        write_regs("part2", 2, 8'h11, 8'h02, 8'hF0, 8'h99, 8'h00);
        check_outs("R4 stop after byte 1");
    endtask

    task automatic t_reserved();
        write_regs("rsv", 3, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'h3F);
        check_outs("R5 reserved bits set, top bits clear");
        write_regs("rsv2", 3, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'hC0);
        check_outs("R5 reserved bits clear, top bits set");
    endtask

    task automatic t_bad_addr();
        bus_start();
        expect_ack("R2 wrong address no ack", 8'hD4, 1'b0);
        expect_ack("R2 byte after wrong address no ack", 8'h00, 1'b0);
        expect_ack("R2 second byte after wrong address", 8'h00, 1'b0);
        bus_stop(); wait_clks(8);
        check_outs("R2 wrong address no change");
        bus_start();
        expect_ack("R2 read bit no ack", 8'hD3, 1'b0);
        expect_ack("R2 byte after read no ack", 8'h00, 1'b0);
        bus_stop(); wait_clks(8);
        check_outs("R2 read request no change");
    endtask

    task automatic t_rep_start();
        bus_start();
        expect_ack("R8 pre address", 8'hD2, 1'b1);
        expect_ack("R8 pre command", 8'h00, 1'b1);
        expect_ack("R8 pre count", 8'h03, 1'b1);
        bus_start();
        expect_ack("R8 address after repeated start", 8'hD2, 1'b0);
        expect_ack("R8 byte after repeated start", 8'h00, 1'b0);
        bus_stop(); wait_clks(8);
        check_outs("R8 abort kept registers");
        write_regs("R8 fresh", 3, 8'h00, 8'h03, 8'h81, 8'h18, 8'hFF);
        check_outs("R8 fresh transfer works");
    endtask

    task automatic t_extra();
        bus_start();
        expect_ack("R9 address", 8'hD2, 1'b1);
        expect_ack("R9 command", 8'h00, 1'b1);
        expect_ack("R9 count", 8'h03, 1'b1);
        expect_ack("R9 data0", 8'h12, 1'b1); mdl[0] = 8'h12;
        expect_ack("R9 data1", 8'h34, 1'b1); mdl[1] = 8'h34;
        expect_ack("R9 data2", 8'h7F, 1'b1); mdl[2] = 8'h7F;
        expect_ack("R9 seventh byte no ack", 8'h00, 1'b0);
        bus_stop(); wait_clks(8);
        check_outs("R9 seventh byte ignored");
    endtask

    task automatic t_commit_edge();
        bus_start();
        expect_ack("R10 address", 8'hD2, 1'b1);
        expect_ack("R10 command", 8'h00, 1'b1);
        expect_ack("R10 count", 8'h03, 1'b1);
        send_bits(8'h00);
        sda_m = 1'b1; wait_clks(Q);
        scl = 1'b1; wait_clks(H);
        check_outs("R10 old value during ack pulse");
        scl = 1'b0; wait_clks(8);
        mdl[0] = 8'h00;
        check_outs("R10 new value after ack falls");
        wait_clks(Q);
        bus_stop(); wait_clks(8);
    endtask

    task automatic t_oe();
        oe = 1'b0; #1;
        chk("R7 oe low drive off", 32'(out_drive), 32'd0);
        wait_clks(4);
        oe = 1'b1; #1;
        chk("R7 oe high drive on", 32'(out_drive), 32'h3FFFF);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) mdl[i] = 8'hFF;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset();
        t_full();
        t_partial();
        t_reserved();
        t_bad_addr();
        t_rep_start();
        t_extra();
        t_commit_edge();
        t_oe();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule